// File: doc/BRIEF.md
# Stereo Digital Volume with Soft Ramp

This block scales a stereo stream of signed PCM samples by a per-channel digital attenuation. A left and a right sample arrive together with one valid strobe. Each channel has an 8-bit volume code in which each count is 0.5 dB of attenuation, so codes 0 to 192 span 0 dB down to about -96 dB. The code is turned into a linear factor, the sample is multiplied by it, and the product is rounded and saturated back to the sample width. The scaled pair leaves the block with its own valid strobe.

Control inputs are plain ports. A lock bit makes the left code govern both channels. A mute bit silences both outputs. A polarity bit per channel negates that channel after scaling. A soft-ramp enable chooses how a change of requested gain takes effect: either at once, or one 0.5 dB step at a time, paced by a 2-bit rate field that counts incoming samples. Soft ramp avoids audible steps when volume or mute changes during playback.

Top module: `vol_stereo_top`

## Requirements
- R1: During and after reset, with no input strobe yet, `out_valid` is 0 and both outputs are 0. Each channel's applied code starts at 192.
- R2: For applied code c, the factor is B[c mod 12] shifted right by (c div 12) bits, where B = {131072, 123740, 116817, 110283, 104114, 98289, 92791, 87600, 82700, 78075, 73707, 69584} (Q1.17, so code 0 is exactly unity). The output is floor((x*factor + 2^16) / 2^17), clamped to the signed sample range.
- R3: A volume code above 192 acts as 192.
- R4: With lock at 0, each channel follows its own code. With lock at 1, the left code sets both channels and the right code has no effect.
- R5: With mute at 1 and soft ramp off, both outputs are 0 for every sample presented while mute is 1, including the sample in the cycle mute rises.
- R6: With soft ramp on and rate r, the applied code moves one step toward the target on every 2^r-th valid sample. Sample i after a target change uses the start code moved by floor(i / 2^r) steps, and the code stops at the target. The sample that triggers a step still uses the code that was applied before the step.
- R7: With soft ramp off, a new target is applied from the next clock on.
- R8: With soft ramp on, mute ramps the applied code to 192 as in R6. Outputs are forced to 0 only once the applied code is 192. Clearing mute ramps back toward the requested code, and no output is forced to 0 on the way.
- R9: Polarity inversion acts on the scaled, saturated value. Inverting the most negative value gives the most positive value.
- R10: A sample pair presented in clock cycle n appears on the outputs with `out_valid` high in cycle n+2. Between strobes, `out_valid` is 0 and the outputs hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample pair strobe |
| in_l | input | DATA_W | Left sample, two's complement |
| in_r | input | DATA_W | Right sample, two's complement |
| vol_l | input | CODE_W | Left volume code, 0.5 dB per count |
| vol_r | input | CODE_W | Right volume code, 0.5 dB per count |
| lock | input | 1 | Left code drives both channels |
| mute | input | 1 | Silence both outputs |
| inv_l | input | 1 | Negate left output |
| inv_r | input | 1 | Negate right output |
| ramp_en | input | 1 | Soft ramp enable |
| ramp_rate | input | RATE_W | Samples per step = 2^ramp_rate |
| out_valid | output | 1 | Output sample pair strobe |
| out_l | output | DATA_W | Left scaled sample |
| out_r | output | DATA_W | Right scaled sample |

## Verification
A wrong applied code shows up at the outputs on the very next valid sample, because each sample is scaled by the code held when it arrives. The bench therefore compares every sample of a ramp against the code that R6 predicts for it, and an off-by-one in the step counter or in the step direction fails within the first 2^r samples. A wrong mute or lock state shows as a nonzero or mismatched output two cycles after the strobe. A pipeline slip shows as `out_valid` arriving in the wrong cycle.

// File: rtl/vol_pkg.sv
package vol_pkg;
    localparam int GAIN_FRAC      = 17;
    localparam int GAIN_W         = GAIN_FRAC + 1;
    localparam int STEPS_PER_HALF = 12;
    localparam int MAX_CODE       = 192;

    // Q1.17 factors for one 6 dB segment, 0.5 dB apart
    function automatic logic [GAIN_W-1:0] seg_gain(input logic [3:0] idx);
        logic [GAIN_W-1:0] g;
        case (idx)
            4'd0:    g = GAIN_W'(131072);
            4'd1:    g = GAIN_W'(123740);
            4'd2:    g = GAIN_W'(116817);
            4'd3:    g = GAIN_W'(110283);
            4'd4:    g = GAIN_W'(104114);
            4'd5:    g = GAIN_W'(98289);
            4'd6:    g = GAIN_W'(92791);
            4'd7:    g = GAIN_W'(87600);
            4'd8:    g = GAIN_W'(82700);
            4'd9:    g = GAIN_W'(78075);
            4'd10:   g = GAIN_W'(73707);
            4'd11:   g = GAIN_W'(69584);
            default: g = '0;
        endcase
        return g;
    endfunction
endpackage

// File: rtl/vol_gain_lut.sv
module vol_gain_lut
    import vol_pkg::*;
#(
    parameter int CODE_W = 8
) (
    input  logic [CODE_W-1:0] code,
    output logic [GAIN_W-1:0] gain
);
    logic [CODE_W-1:0] octave;
    logic [3:0]        seg;

    always_comb begin
        octave = code / CODE_W'(STEPS_PER_HALF);
        seg    = 4'(code % CODE_W'(STEPS_PER_HALF));
        gain   = seg_gain(seg) >> octave;
    end
endmodule

// File: rtl/vol_ramp.sv
module vol_ramp
    import vol_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ramp_en,
    input  logic [RATE_W-1:0] rate,
    input  logic              in_valid,
    input  logic [CODE_W-1:0] target,
    output logic [CODE_W-1:0] applied
);
    localparam int CNT_W = (1 << RATE_W) - 1;
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(MAX_CODE);

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [CNT_W-1:0]  cnt;
    } ramp_t;

    ramp_t             st_d, st_q;
    logic [CNT_W-1:0]  limit;

    always_comb begin
        limit = CNT_W'((1 << rate) - 1);
        st_d  = st_q;
        if (!ramp_en) begin
            st_d.code = target;
            st_d.cnt  = '0;
        end else if (st_q.code == target) begin
            st_d.cnt = '0;
        end else if (in_valid) begin
            if (st_q.cnt == limit) begin
                st_d.cnt  = '0;
                st_d.code = (st_q.code < target) ? st_q.code + CODE_W'(1)
                                                 : st_q.code - CODE_W'(1);
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.code <= TOP_CODE;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign applied = st_q.code;

    // R6: while ramping, the code moves by at most one step per clock
    a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ramp_en) |-> (st_q.code == $past(st_q.code) ||
                            st_q.code == $past(st_q.code) + CODE_W'(1) ||
                            st_q.code == $past(st_q.code) - CODE_W'(1)));

    // R6: a ramp step never moves away from the target
    a_r6_toward_target: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ramp_en) && $past(st_q.code) < $past(target)) |-> st_q.code >= $past(st_q.code));

    // R3: applied code stays inside the valid range
    a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.code <= TOP_CODE);
endmodule

// File: rtl/vol_scale.sv
module vol_scale
    import vol_pkg::*;
#(
    parameter int DATA_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] sample,
    input  logic [GAIN_W-1:0] gain,
    input  logic              inv,
    input  logic              zero,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    localparam int PROD_W = DATA_W + GAIN_W + 1;
    localparam logic signed [PROD_W-1:0] P_MAX =
        {{(PROD_W-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [PROD_W-1:0] P_MIN =
        {{(PROD_W-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};
    localparam logic signed [PROD_W-1:0] P_HALF = PROD_W'(1) <<< (GAIN_FRAC - 1);
    localparam logic [DATA_W-1:0] D_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic [DATA_W-1:0] D_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef struct packed {
        logic                     valid;
        logic signed [PROD_W-1:0] prod;
        logic                     inv;
        logic                     zero;
        logic                     ovalid;
        logic [DATA_W-1:0]        data;
    } pipe_t;

    pipe_t                    st_d, st_q;
    logic signed [PROD_W-1:0] rounded;
    logic [DATA_W-1:0]        sat;

    always_comb begin
        st_d = st_q;
        // stage 1: multiply
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.prod = PROD_W'($signed(sample)) * $signed({1'b0, gain});
            st_d.inv  = inv;
            st_d.zero = zero;
        end
        // stage 2: round, saturate, invert, zero
        rounded = (st_q.prod + P_HALF) >>> GAIN_FRAC;
        if (rounded > P_MAX)      sat = D_MAX;
        else if (rounded < P_MIN) sat = D_MIN;
        else                      sat = rounded[DATA_W-1:0];
        st_d.ovalid = st_q.valid;
        if (st_q.valid) begin
            if (st_q.zero)      st_d.data = '0;
            else if (!st_q.inv) st_d.data = sat;
            else if (sat == D_MIN) st_d.data = D_MAX;
            else                st_d.data = -sat;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.ovalid;
    assign out_data  = st_q.data;

    // R9: an inverted result never lands on the most negative value
    a_r9_inv_no_min: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.inv && !st_q.zero) |=> (st_q.data != D_MIN));

    // R5: a zero-flagged sample leaves as zero
    a_r5_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.valid && st_q.zero) |=> (st_q.data == '0));

    // R10: data holds between strobes
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.valid |=> $stable(st_q.data));
endmodule

// File: rtl/vol_stereo_top.sv
module vol_stereo_top
    import vol_pkg::*;
#(
    parameter int DATA_W = 24,
    parameter int CODE_W = 8,
    parameter int RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_l,
    input  logic [DATA_W-1:0] in_r,
    input  logic [CODE_W-1:0] vol_l,
    input  logic [CODE_W-1:0] vol_r,
    input  logic              lock,
    input  logic              mute,
    input  logic              inv_l,
    input  logic              inv_r,
    input  logic              ramp_en,
    input  logic [RATE_W-1:0] ramp_rate,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_l,
    output logic [DATA_W-1:0] out_r
);
    localparam int NCH = 2;
    localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(MAX_CODE);

    logic [CODE_W-1:0] req_code [NCH];
    logic [CODE_W-1:0] tgt      [NCH];
    logic [CODE_W-1:0] applied  [NCH];
    logic [GAIN_W-1:0] gain     [NCH];
    logic [DATA_W-1:0] smp      [NCH];
    logic [DATA_W-1:0] res      [NCH];
    logic              inv      [NCH];
    logic              zero     [NCH];
    logic              vld      [NCH];

    assign req_code[0] = vol_l;
    assign req_code[1] = lock ? vol_l : vol_r;
    assign smp[0]      = in_l;
    assign smp[1]      = in_r;
    assign inv[0]      = inv_l;
    assign inv[1]      = inv_r;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign tgt[ch]  = mute ? TOP_CODE
                        : ((req_code[ch] > TOP_CODE) ? TOP_CODE : req_code[ch]);
        assign zero[ch] = mute && (!ramp_en || applied[ch] == TOP_CODE);

        vol_ramp #(.CODE_W(CODE_W), .RATE_W(RATE_W)) u_ramp (
            .clk      (clk),
            .rst_n    (rst_n),
            .ramp_en  (ramp_en),
            .rate     (ramp_rate),
            .in_valid (in_valid),
            .target   (tgt[ch]),
            .applied  (applied[ch])
        );

        vol_gain_lut #(.CODE_W(CODE_W)) u_lut (
            .code (applied[ch]),
            .gain (gain[ch])
        );

        vol_scale #(.DATA_W(DATA_W)) u_scale (
            .clk       (clk),
            .rst_n     (rst_n),
            .in_valid  (in_valid),
            .sample    (smp[ch]),
            .gain      (gain[ch]),
            .inv       (inv[ch]),
            .zero      (zero[ch]),
            .out_valid (vld[ch]),
            .out_data  (res[ch])
        );
    end

    assign out_valid = vld[0] & vld[1];
    assign out_l     = res[0];
    assign out_r     = res[1];

    // R10: a strobe in cycle n yields an output strobe in cycle n+2
    a_r10_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> ##2 !out_valid);

    // R5: mute without ramp silences the sample presented with it
    a_r5_mute_now: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && mute && !ramp_en) |-> ##2 (out_l == '0 && out_r == '0));
endmodule

// File: tb/sim_vol_stereo_top.sv
module sim_vol_stereo_top;
    localparam int DATA_W = 24;
    localparam int CODE_W = 8;
    localparam int RATE_W = 2;
    localparam longint SMAX = (64'sd1 <<< (DATA_W-1)) - 1;
    localparam longint SMIN = -(64'sd1 <<< (DATA_W-1));

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_l = '0, in_r = '0;
    logic [CODE_W-1:0] vol_l = '0, vol_r = '0;
    logic              lock = 1'b0, mute = 1'b0, inv_l = 1'b0, inv_r = 1'b0;
    logic              ramp_en = 1'b0;
    logic [RATE_W-1:0] ramp_rate = '0;
    logic              out_valid;
    logic [DATA_W-1:0] out_l, out_r;

    int n_chk = 0;
    int n_bad = 0;
    longint got_l, got_r;
    logic   got_v;

    always #2 clk = ~clk;

    vol_stereo_top #(.DATA_W(DATA_W), .CODE_W(CODE_W), .RATE_W(RATE_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_l(in_l), .in_r(in_r),
        .vol_l(vol_l), .vol_r(vol_r), .lock(lock), .mute(mute),
        .inv_l(inv_l), .inv_r(inv_r), .ramp_en(ramp_en), .ramp_rate(ramp_rate),
        .out_valid(out_valid), .out_l(out_l), .out_r(out_r)
    );

    function automatic longint seg_tab(input int m);
        case (m)
            0: return 131072;  1: return 123740;  2: return 116817;
            3: return 110283;  4: return 104114;  5: return 98289;
            6: return 92791;   7: return 87600;   8: return 82700;
            9: return 78075;   10: return 73707;  default: return 69584;
        endcase
    endfunction

    function automatic longint model(input longint x, input int code, input bit inv, input bit zero);
        int c;
        longint f, y;
        c = (code > 192) ? 192 : code;
        f = seg_tab(c % 12) >>> (c / 12);
        y = (x * f + 65536) >>> 17;
        if (y > SMAX) y = SMAX;
        if (y < SMIN) y = SMIN;
        if (inv) y = (y == SMIN) ? SMAX : -y;
        if (zero) y = 0;
        return y;
    endfunction

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input longint l, input longint r);
        in_l = DATA_W'(l);
        in_r = DATA_W'(r);
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        got_v = out_valid;
        got_l = longint'($signed(out_l));
        got_r = longint'($signed(out_r));
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R1 valid", longint'(out_valid), 0);
        chk("R1 out_l", longint'(out_l), 0);
        chk("R1 out_r", longint'(out_r), 0);
    endtask

    task automatic t_unity();
        vol_l = 0; vol_r = 0; settle();
        send(SMAX, SMIN);
        chk("R2 unity l", got_l, SMAX);
        chk("R2 unity r", got_r, SMIN);
        send(-12345, 777);
        chk("R7 immediate l", got_l, -12345);
        chk("R2 unity r2", got_r, 777);
    endtask

    task automatic t_codes();
        int codes [6] = '{1, 12, 13, 100, 192, 250};
        foreach (codes[k]) begin
            vol_l = CODE_W'(codes[k]); vol_r = CODE_W'(codes[k]); settle();
            send(5000000, -3333333);
            chk(codes[k] > 192 ? "R3 clamp l" : "R2 law l", got_l, model(5000000, codes[k], 0, 0));
            chk(codes[k] > 192 ? "R3 clamp r" : "R2 law r", got_r, model(-3333333, codes[k], 0, 0));
        end
    endtask

    task automatic t_lock();
        vol_l = 6; vol_r = 40; lock = 0; settle();
        send(1000000, 1000000);
        chk("R4 own l", got_l, model(1000000, 6, 0, 0));
        chk("R4 own r", got_r, model(1000000, 40, 0, 0));
        lock = 1; settle();
        send(1000000, 1000000);
        chk("R4 lock l", got_l, model(1000000, 6, 0, 0));
        chk("R4 lock r", got_r, model(1000000, 6, 0, 0));
        lock = 0;
    endtask

    task automatic t_invert();
        vol_l = 0; vol_r = 12; inv_l = 1; inv_r = 1; settle();
        send(SMIN, -5);
        chk("R9 min to max", got_l, SMAX);
        chk("R9 after scale", got_r, model(-5, 12, 1, 0));
        send(SMAX, 1000);
        chk("R9 neg max", got_l, -SMAX);
        chk("R9 neg r", got_r, model(1000, 12, 1, 0));
        inv_l = 0; inv_r = 0;
    endtask

    task automatic t_mute_now();
        vol_l = 0; vol_r = 0; settle();
        mute = 1;
        send(400000, -400000);
        chk("R5 l", got_l, 0);
        chk("R5 r", got_r, 0);
        mute = 0; settle();
    endtask

    task automatic t_latency();
        in_l = 24'd99; in_r = 24'd99; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 not yet", longint'(out_valid), 0);
        @(negedge clk);
        chk("R10 strobe", longint'(out_valid), 1);
        chk("R10 data", longint'($signed(out_l)), model(99, 0, 0, 0));
        @(negedge clk);
        chk("R10 drop", longint'(out_valid), 0);
        chk("R10 hold", longint'($signed(out_l)), model(99, 0, 0, 0));
    endtask

    task automatic t_ramp();
        ramp_en = 0; vol_l = 0; vol_r = 0; settle();
        ramp_en = 1; ramp_rate = 1; vol_l = 4; vol_r = 4;
        for (int i = 0; i < 12; i++) begin
            int c;
            c = (i / 2 > 4) ? 4 : i / 2;
            send(2000000, -2000000);
            chk("R6 up l", got_l, model(2000000, c, 0, 0));
            chk("R6 up r", got_r, model(-2000000, c, 0, 0));
        end
        ramp_rate = 0; vol_l = 0; vol_r = 0;
        for (int i = 0; i < 6; i++) begin
            int c;
            c = (4 - i < 0) ? 0 : 4 - i;
            send(2000000, 2000000);
            chk("R6 down", got_l, model(2000000, c, 0, 0));
        end
        ramp_rate = 2; vol_l = 1; vol_r = 1;
        for (int i = 0; i < 5; i++) begin
            send(2000000, 2000000);
            chk("R6 rate2", got_l, model(2000000, (i < 4) ? 0 : 1, 0, 0));
        end
        ramp_en = 0;
    endtask

    task automatic t_ramp_mute();
        ramp_en = 0; vol_l = 188; vol_r = 188; settle();
        ramp_en = 1; ramp_rate = 0; mute = 1;
        for (int i = 0; i < 6; i++) begin
            int c;
            c = (188 + i > 192) ? 192 : 188 + i;
            send(3000000, 3000000);
            chk("R8 ramp down", got_l, model(3000000, c, 0, c == 192));
            chk("R8 ramp down r", got_r, model(3000000, c, 0, c == 192));
        end
        mute = 0;
        for (int i = 0; i < 6; i++) begin
            int c;
            c = (192 - i < 188) ? 188 : 192 - i;
            send(3000000, 3000000);
            chk("R8 ramp up", got_l, model(3000000, c, 0, 0));
        end
        ramp_en = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_unity();
        t_codes();
        t_lock();
        t_invert();
        t_mute_now();
        t_latency();
        t_ramp();
        t_ramp_mute();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule